// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Expander

This block collects a large set of interrupt request lines and presents them to a CPU that has only a few interrupt inputs. The request lines are split into groups. Each group latches rising edges of its lines in a flag register and masks them with an enable register. It then merges its enabled, pending flags into one request line for the CPU. Each group also holds an acknowledge bit. While that bit is set, the group cannot forward another request, so only one request per group is outstanding at a time.

The second stage keeps a CPU-level flag and enable bit for each group line, plus one global mask bit that blocks every interrupt. The block picks the highest-priority pending source, reports its source number, and completes the take when the CPU signals that it has accepted the interrupt. Software can raise any flag at either level directly, so spare request positions can serve as software interrupts.

Top module: `gie_top`

## Requirements
- R1: After reset all flags, enables and acknowledge bits are 0, the global mask is 1, `irq_o` is 0 and `irq_valid_o` is 0.
- R2: A 0-to-1 transition on `req_i[s]` sets flag bit `s%8` of group `s/8` at the next clock edge. A line held high does not set the flag again after it has been cleared.
- R3: A group whose flag and enable registers share a set bit and whose acknowledge bit is 0 sets its CPU flag bit at the next clock edge.
- R4: `irq_o[g]` is 1 exactly when CPU flag bit g and CPU enable bit g are both 1 and the global mask is 0. `irq_valid_o` is the OR of `irq_o`.
- R5: The lowest-numbered group with an active `irq_o` bit wins. Within that group, the lowest-numbered flag that is both set and enabled wins. `irq_id_o` = group*8 + index.
- R6: `take_i` together with `irq_valid_o` does three things at the next edge: it clears the winning group's CPU flag bit, clears the winning group flag bit, and sets that group's acknowledge bit.
- R7: While a group's acknowledge bit is 1, the group does not set its CPU flag. Writing 1 to an acknowledge bit clears it, and the group then forwards its next pending flag.
- R8: Writes to group flag registers and to the CPU flag register set each bit written as 1. Bits written as 0 are left unchanged.
- R9: Register map (6-bit address, 16-bit data): group g enable at 0x00+g, group g flag at 0x10+g, CPU enable at 0x20 (bits 11:0), CPU flag at 0x21, acknowledge bits at 0x22 (write 1 to clear), global mask at 0x23 bit 0. Reads are combinational on `reg_addr_i`.
- R10: `take_i` while `irq_valid_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 96 | Interrupt request lines, edge detected |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| take_i | input | 1 | CPU accepts the presented interrupt |
| irq_o | output | 12 | Interrupt lines to the CPU |
| irq_valid_o | output | 1 | Some interrupt is presented |
| irq_id_o | output | 7 | Source number of the winning request |

## Verification
The assertions assume that `take_i` is held for one cycle per accepted interrupt. They also assume that software does not clear an acknowledge bit in the same cycle that the CPU takes an interrupt from that group. The take check relies on the take-clear overriding any software set of the same CPU flag. The stimulus issues takes only as single-cycle pulses while an interrupt is presented, and it performs acknowledge writes only in cycles without a take. It drives request edges one group bit at a time, or uses software sets, so that every expected flag pattern follows from the source number.

// File: rtl/gie_pkg.sv
package gie_pkg;
  localparam int DEF_NUM_GRP = 12;
  localparam int DEF_GRP_W   = 8;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 16;
  localparam logic [1:0] SPC_GEN = 2'd0;
  localparam logic [1:0] SPC_GFL = 2'd1;
  localparam logic [1:0] SPC_TOP = 2'd2;
  localparam logic [3:0] TOP_CEN = 4'd0;
  localparam logic [3:0] TOP_CFL = 4'd1;
  localparam logic [3:0] TOP_ACK = 4'd2;
  localparam logic [3:0] TOP_GMK = 4'd3;
endpackage

// File: rtl/gie_grp_unit.sv
module gie_grp_unit #(
  parameter int GRP_W = 8,
  localparam int IDX_W = $clog2(GRP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] req_i,
  input  logic             en_we_i,
  input  logic [GRP_W-1:0] en_wdata_i,
  input  logic [GRP_W-1:0] flg_set_i,
  input  logic             take_i,
  input  logic             ack_i,
  output logic [GRP_W-1:0] en_o,
  output logic [GRP_W-1:0] flg_o,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [GRP_W-1:0] req_q, rise, pend, clr;

  assign rise = req_i & ~req_q;
  assign pend = flg_o & en_o;
  assign req_o = (|pend) & ~ack_i;

  always_comb begin
    idx_o = '0;
    for (int i = GRP_W - 1; i >= 0; i--)
      if (pend[i]) idx_o = IDX_W'(i);
  end

  assign clr = take_i ? (GRP_W'(1) << idx_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_o  <= '0;
      flg_o <= '0;
    end else begin
      req_q <= req_i;
      if (en_we_i) en_o <= en_wdata_i;
      // new event wins over the take-clear of the same bit
      flg_o <= (flg_o & ~clr) | rise | flg_set_i;
    end
  end

  // R2
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flg_o & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gie_cpu_stage.sv
module gie_cpu_stage #(
  parameter int NUM_GRP = 12,
  localparam int SEL_W = $clog2(NUM_GRP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] grp_req_i,
  input  logic               en_we_i,
  input  logic [NUM_GRP-1:0] en_wdata_i,
  input  logic [NUM_GRP-1:0] flg_set_i,
  input  logic               gmask_we_i,
  input  logic               gmask_wdata_i,
  input  logic               take_i,
  output logic [NUM_GRP-1:0] en_o,
  output logic [NUM_GRP-1:0] flg_o,
  output logic               gmask_o,
  output logic [NUM_GRP-1:0] irq_o,
  output logic               valid_o,
  output logic [SEL_W-1:0]   sel_o
);
  logic [NUM_GRP-1:0] clr;

  assign irq_o   = flg_o & en_o & {NUM_GRP{~gmask_o}};
  assign valid_o = |irq_o;

  always_comb begin
    sel_o = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--)
      if (irq_o[g]) sel_o = SEL_W'(g);
  end

  assign clr = (take_i && valid_o) ? (NUM_GRP'(1) << sel_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      flg_o   <= '0;
      gmask_o <= 1'b1;
    end else begin
      if (en_we_i)    en_o    <= en_wdata_i;
      if (gmask_we_i) gmask_o <= gmask_wdata_i;
      // take-clear wins over set
      flg_o <= (flg_o | grp_req_i | flg_set_i) & ~clr;
    end
  end

  // R6
  take_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && valid_o |=> !flg_o[$past(sel_o)]);
  // R4
  gmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask_o |-> !valid_o);
endmodule

// File: rtl/gie_top.sv
module gie_top
  import gie_pkg::*;
#(
  parameter int NUM_GRP = DEF_NUM_GRP,
  parameter int GRP_W   = DEF_GRP_W,
  localparam int NUM_SRC = NUM_GRP * GRP_W,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int SEL_W   = $clog2(NUM_GRP),
  localparam int IDX_W   = $clog2(GRP_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               take_i,
  output logic [NUM_GRP-1:0] irq_o,
  output logic               irq_valid_o,
  output logic [ID_W-1:0]    irq_id_o
);
  logic [1:0] spc;
  logic [3:0] sub;
  logic [NUM_GRP-1:0] grp_req, ack_q, cen, cfl;
  logic [GRP_W-1:0]   gen [NUM_GRP];
  logic [GRP_W-1:0]   gfl [NUM_GRP];
  logic [IDX_W-1:0]   gidx [NUM_GRP];
  logic [SEL_W-1:0]   sel;
  logic               gmask, take_fire;

  assign spc = reg_addr_i[5:4];
  assign sub = reg_addr_i[3:0];
  assign take_fire = take_i & irq_valid_o;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = reg_we_i && (sub == 4'(g));
    gie_grp_unit #(.GRP_W(GRP_W)) u_grp (
      .clk_i, .rst_ni,
      .req_i      (req_i[g*GRP_W +: GRP_W]),
      .en_we_i    (hit && spc == SPC_GEN),
      .en_wdata_i (reg_wdata_i[GRP_W-1:0]),
      .flg_set_i  ((hit && spc == SPC_GFL) ? reg_wdata_i[GRP_W-1:0] : '0),
      .take_i     (take_fire && sel == SEL_W'(g)),
      .ack_i      (ack_q[g]),
      .en_o       (gen[g]),
      .flg_o      (gfl[g]),
      .req_o      (grp_req[g]),
      .idx_o      (gidx[g])
    );
  end

  logic top_we;
  assign top_we = reg_we_i && spc == SPC_TOP;

  gie_cpu_stage #(.NUM_GRP(NUM_GRP)) u_cpu (
    .clk_i, .rst_ni,
    .grp_req_i     (grp_req),
    .en_we_i       (top_we && sub == TOP_CEN),
    .en_wdata_i    (reg_wdata_i[NUM_GRP-1:0]),
    .flg_set_i     ((top_we && sub == TOP_CFL) ? reg_wdata_i[NUM_GRP-1:0] : '0),
    .gmask_we_i    (top_we && sub == TOP_GMK),
    .gmask_wdata_i (reg_wdata_i[0]),
    .take_i        (take_i),
    .en_o          (cen),
    .flg_o         (cfl),
    .gmask_o       (gmask),
    .irq_o         (irq_o),
    .valid_o       (irq_valid_o),
    .sel_o         (sel)
  );

  assign irq_id_o = ID_W'(sel) * ID_W'(GRP_W) + ID_W'(gidx[sel]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= '0;
    else begin
      logic [NUM_GRP-1:0] nxt;
      nxt = ack_q;
      if (top_we && sub == TOP_ACK) nxt = nxt & ~reg_wdata_i[NUM_GRP-1:0];
      if (take_fire) nxt[sel] = 1'b1;
      ack_q <= nxt;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (spc)
      SPC_GEN: if (sub < 4'(NUM_GRP)) reg_rdata_o = DATA_W'(gen[sub]);
      SPC_GFL: if (sub < 4'(NUM_GRP)) reg_rdata_o = DATA_W'(gfl[sub]);
      SPC_TOP: begin
        case (sub)
          TOP_CEN: reg_rdata_o = DATA_W'(cen);
          TOP_CFL: reg_rdata_o = DATA_W'(cfl);
          TOP_ACK: reg_rdata_o = DATA_W'(ack_q);
          TOP_GMK: reg_rdata_o = DATA_W'(gmask);
          default: reg_rdata_o = '0;
        endcase
      end
      default: reg_rdata_o = '0;
    endcase
  end

  // R6 R7
  ack_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_fire |=> ack_q[$past(sel)]);
endmodule

// File: tb/tb_gie_top.sv
`timescale 1ns/1ps
module tb_gie_top;
  logic        clk = 0, rst_n = 0;
  logic [95:0] req = '0;
  logic        we = 0, take = 0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [11:0] irq;
  logic        valid;
  logic [6:0]  id;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gie_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .take_i(take), .irq_o(irq),
    .irq_valid_o(valid), .irq_id_o(id)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic do_take;
    take = 1; @(negedge clk); take = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h23, d); chk("R1 gmask", d, 1);
    rd(6'h20, d); chk("R1 cpu_en", d, 0);
    rd(6'h22, d); chk("R1 ack", d, 0);
    rd(6'h10, d); chk("R1 gflag0", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 valid", valid, 0);

    for (int g = 0; g < 12; g++) wr(6'(g), 16'hff);
    wr(6'h20, 16'hfff);
    rd(6'h05, d); chk("R9 gen5", d, 16'hff);
    wr(6'h23, 0);

    // R2 R3 R4 R5 R6 R7 sweep over every source
    for (int s = 0; s < 96; s++) begin
      int g, i;
      g = s / 8; i = s % 8;
      req[s] = 1;
      @(negedge clk);
      rd(6'(16 + g), d); chk("R2 flag set", d, 1 << i);
      @(negedge clk);
      chk("R3 R4 irq", irq, 1 << g);
      chk("R5 id", id, s);
      do_take;
      chk("R6 irq cleared", irq, 0);
      rd(6'h22, d); chk("R6 ack set", d, 1 << g);
      rd(6'(16 + g), d); chk("R6 flag cleared", d, 0);
      @(negedge clk);
      rd(6'(16 + g), d); chk("R2 level no retrigger", d, 0);
      req[s] = 0;
      wr(6'h22, 16'(1 << g));
      rd(6'h22, d); chk("R7 ack cleared", d, 0);
    end

    // R5 R7 R8 priority across and within groups via software set
    for (int g = 0; g < 11; g++) begin
      wr(6'(16 + g + 1), 16'h01);
      wr(6'(16 + g), 16'h24);
      @(negedge clk);
      chk("R5 R8 id first", id, g * 8 + 2);
      do_take;
      chk("R5 id next group", id, (g + 1) * 8);
      do_take;
      @(negedge clk);
      rd(6'h21, d); chk("R7 blocked", d, 0);
      rd(6'(16 + g), d); chk("R7 flag held", d, 16'h20);
      wr(6'h22, 16'hfff);
      @(negedge clk);
      chk("R7 forward after ack", id, g * 8 + 5);
      do_take;
      wr(6'h22, 16'hfff);
      chk("R6 idle", valid, 0);
    end

    // R8 write of zero leaves flag unchanged
    wr(6'h13, 16'h80);
    wr(6'h13, 16'h00);
    rd(6'h13, d); chk("R8 w0", d, 16'h80);
    // R4 R10 global mask blocks, take ignored
    wr(6'h23, 1);
    @(negedge clk);
    chk("R4 masked irq", irq, 0);
    chk("R4 masked valid", valid, 0);
    do_take;
    rd(6'h21, d); chk("R10 cpu flag kept", d, 16'h008);
    rd(6'h22, d); chk("R10 ack kept", d, 0);
    rd(6'h13, d); chk("R10 gflag kept", d, 16'h80);
    wr(6'h23, 0);
    chk("R4 unmask irq", irq, 12'h008);
    chk("R5 id", id, 31);
    // R4 cpu enable gates
    wr(6'h20, 16'hff7);
    chk("R4 cpu en off", irq, 0);
    wr(6'h21, 16'h400);
    chk("R8 R4 cpu sw set", irq, 12'h400);
    rd(6'h21, d); chk("R8 cpu flag", d, 16'h408);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule